// File: doc/BRIEF.md
# Self-Repairing Minutes:Seconds Counter Array

This block is a row of identical digit cells that together keep a minutes:seconds clock running from 00:00 to 59:59. No cell has a fixed role. Each cell holds the behaviour of every role. It works out a position number from its left neighbour, and that number picks its behaviour. Positions 1 and 3 count modulo 6, and positions 2 and 4 count modulo 10. Read left to right, one group of four positions forms tens-of-minutes, minutes, tens-of-seconds and seconds.

Cells to the right of the first group are spares. Positions wrap from 4 back to 1, so each further run of four working cells repeats the same clock and counts in step with the first. A cell that is marked faulty is skipped. Its left neighbour's position and the carry coming from its right pass straight through it. Every cell to its right then moves one role to the right. After any change to the fault marks, a short sequencer clears every digit. The assembled time is read from the first four working cells.

The sequencer has two states. ST_RUN is normal counting. ST_CLEAR is a one-cycle digit wipe. The transition RUN→CLEAR is taken when the fault marks differ from their registered copy. CLEAR→CLEAR is taken when they differ again. CLEAR→RUN is taken otherwise.

Top module: `selfheal_clock`

## Requirements
- R1: Among the cells not marked faulty, taken left to right, the positions are 1,2,3,4,1,2,3,4,… A faulty cell takes no position and does not break the sequence.
- R2: A working cell at position 1 or 3 counts 0..5 and wraps to 0. A working cell at position 2 or 4 counts 0..9 and wraps to 0.
- R3: A working cell at position 4 advances on each clock edge where tick_i is high. Any other working cell advances when the next working cell to its right wraps from its maximum to 0 on that edge. The wrap of a position-1 cell is not passed to the left.
- R4: Each complete group of four working cells counts modulo 3600. One tick at 59:59 gives 00:00.
- R5: A cell marked faulty shows digit 0 on digit_o in ST_RUN and never advances.
- R6: On an edge where fault_i differs from its registered copy, the copy is updated and the sequencer enters ST_CLEAR. On the following edge all digits become 0 and tick_i is ignored. Counting resumes on the edge after that.
- R7: time_o holds the digits of the first four working cells, in the order bits [15:12], [11:8], [7:4], [3:0]. time_valid_o is 1 exactly when at least four cells are working. Otherwise time_o is 0.
- R8: While reset is asserted, all digits and time_o are 0.
- R9: Working cells in a trailing run of fewer than four stay at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-second advance pulse |
| fault_i | input | NUM_CELLS | Per-cell faulty mark, bit i for cell i (cell 0 leftmost) |
| digit_o | output | NUM_CELLS*DIGIT_W | Digit of cell i at bits [i*DIGIT_W +: DIGIT_W] |
| time_o | output | 4*DIGIT_W | Assembled time, tens of minutes in the top nibble |
| time_valid_o | output | 1 | A complete group of four working cells exists |

## Verification
The bench builds the block with the default eight cells and four-bit digits. With those values there can be two full replicas at once, a trailing partial replica after one or two bypasses, and a case with too few working cells for any valid time. With eight cells the bench can also place faults at the leftmost cell, inside the first group and at the far right. In each case the bench checks that every complete replica shows the same time, and it drives full 3600-tick runs to reach the 59:59 wrap.

// File: rtl/shc_pkg.sv
package shc_pkg;

    localparam int unsigned GROUP_LEN = 4;

    typedef logic [2:0] coord_t;

    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_CLEAR = 1'b1
    } seq_state_e;

    function automatic coord_t coord_step(coord_t c);
        coord_t r;
        if (c >= coord_t'(GROUP_LEN)) r = coord_t'(1);
        else                          r = c + coord_t'(1);
        return r;
    endfunction

    function automatic logic [3:0] digit_max(coord_t c);
        logic [3:0] r;
        if (c[0]) r = 4'd5;
        else      r = 4'd9;
        return r;
    endfunction

endpackage

// File: rtl/shc_seq.sv
module shc_seq
    import shc_pkg::*;
#(
    parameter int unsigned NUM_CELLS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CELLS-1:0] fault_i,
    output logic [NUM_CELLS-1:0] fault_q,
    output seq_state_e           state_o,
    output logic                 clear_o
);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       marks_changed;

    assign marks_changed = (fault_i != fault_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            fault_q <= '0;
        end else begin
            state_q <= state_d;
            fault_q <= fault_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   state_d = marks_changed ? ST_CLEAR : ST_RUN;
            ST_CLEAR: state_d = marks_changed ? ST_CLEAR : ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_comb begin
        clear_o = 1'b0;
        unique case (state_q)
            ST_RUN:   clear_o = 1'b0;
            ST_CLEAR: clear_o = 1'b1;
            default:  clear_o = 1'b0;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/shc_cell.sv
module shc_cell
    import shc_pkg::*;
#(
    parameter int unsigned DIGIT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               bypass_i,
    input  logic               tick_i,
    input  coord_t             coord_in,
    output coord_t             coord_out,
    input  logic               carry_in,
    output logic               carry_out,
    output logic [DIGIT_W-1:0] digit_o
);

    coord_t             own_coord;
    logic [DIGIT_W-1:0] top_val;
    logic               advance;
    logic               wraps;

    assign own_coord = coord_step(coord_in);
    assign top_val   = DIGIT_W'(digit_max(own_coord));
    assign coord_out = bypass_i ? coord_in : own_coord;

    always_comb begin
        advance = 1'b0;
        if (!bypass_i) begin
            if (own_coord == coord_t'(GROUP_LEN)) advance = tick_i;
            else                                  advance = carry_in;
        end
    end

    assign wraps     = advance && (digit_o == top_val);
    assign carry_out = bypass_i ? carry_in : wraps;

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            digit_o <= '0;
        end else if (advance) begin
            digit_o <= wraps ? '0 : digit_o + DIGIT_W'(1);
        end
    end

endmodule

// File: rtl/shc_pick.sv
module shc_pick
    import shc_pkg::*;
#(
    parameter int unsigned NUM_CELLS = 8,
    parameter int unsigned DIGIT_W   = 4
) (
    input  logic [NUM_CELLS*DIGIT_W-1:0] digit_i,
    input  logic [NUM_CELLS-1:0]         fault_i,
    output logic [GROUP_LEN*DIGIT_W-1:0] time_o,
    output logic                         valid_o
);

    localparam int unsigned TW = GROUP_LEN * DIGIT_W;

    logic [TW-1:0] acc;
    int unsigned   taken;

    always_comb begin
        acc   = '0;
        taken = 0;
        for (int unsigned i = 0; i < NUM_CELLS; i++) begin
            if (!fault_i[i] && taken < GROUP_LEN) begin
                acc   = {acc[TW-DIGIT_W-1:0], digit_i[i*DIGIT_W +: DIGIT_W]};
                taken = taken + 1;
            end
        end
        valid_o = (taken == GROUP_LEN);
        time_o  = valid_o ? acc : '0;
    end

endmodule

// File: rtl/selfheal_clock.sv
module selfheal_clock
    import shc_pkg::*;
#(
    parameter int unsigned NUM_CELLS = 8,
    parameter int unsigned DIGIT_W   = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tick_i,
    input  logic [NUM_CELLS-1:0]         fault_i,
    output logic [NUM_CELLS*DIGIT_W-1:0] digit_o,
    output logic [4*DIGIT_W-1:0]         time_o,
    output logic                         time_valid_o
);

    logic [NUM_CELLS-1:0] fault_q;
    seq_state_e           state;
    logic                 clear;
    coord_t               coord_c [NUM_CELLS+1];
    logic                 cy      [NUM_CELLS+1];

    shc_seq #(.NUM_CELLS(NUM_CELLS)) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .fault_i (fault_i),
        .fault_q (fault_q),
        .state_o (state),
        .clear_o (clear)
    );

    assign coord_c[0]  = coord_t'(GROUP_LEN);
    assign cy[NUM_CELLS] = 1'b0;

    for (genvar g = 0; g < NUM_CELLS; g++) begin : g_cell
        shc_cell #(.DIGIT_W(DIGIT_W)) cell_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear_i   (clear),
            .bypass_i  (fault_q[g]),
            .tick_i    (tick_i),
            .coord_in  (coord_c[g]),
            .coord_out (coord_c[g+1]),
            .carry_in  (cy[g+1]),
            .carry_out (cy[g]),
            .digit_o   (digit_o[g*DIGIT_W +: DIGIT_W])
        );
    end

    shc_pick #(.NUM_CELLS(NUM_CELLS), .DIGIT_W(DIGIT_W)) pick_i (
        .digit_i (digit_o),
        .fault_i (fault_q),
        .time_o  (time_o),
        .valid_o (time_valid_o)
    );

endmodule

// File: rtl/shc_chk.sv
module shc_chk
    import shc_pkg::*;
#(
    parameter int unsigned NUM_CELLS = 8,
    parameter int unsigned DIGIT_W   = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         tick_i,
    input logic [NUM_CELLS-1:0]         fault_i,
    input logic [NUM_CELLS*DIGIT_W-1:0] digit_o,
    input logic [4*DIGIT_W-1:0]         time_o,
    input logic                         time_valid_o,
    input logic [NUM_CELLS-1:0]         fault_q,
    input seq_state_e                   state
);

    logic [NUM_CELLS*DIGIT_W-1:0] skip_mask;

    always_comb begin
        for (int unsigned i = 0; i < NUM_CELLS; i++)
            skip_mask[i*DIGIT_W +: DIGIT_W] = {DIGIT_W{fault_q[i]}};
    end

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_CLEAR |=> digit_o == '0); // R6

    AST_BYPASS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_RUN |-> (digit_o & skip_mask) == '0); // R5

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !tick_i && fault_i == fault_q) |=> $stable(digit_o)); // R3

    AST_TENS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        time_valid_o |-> (time_o[4*DIGIT_W-1 -: DIGIT_W] <= 5 && time_o[2*DIGIT_W-1 -: DIGIT_W] <= 5)); // R2

    AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !time_valid_o |-> time_o == '0); // R7

endmodule

bind selfheal_clock shc_chk #(.NUM_CELLS(NUM_CELLS), .DIGIT_W(DIGIT_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .fault_i      (fault_i),
    .digit_o      (digit_o),
    .time_o       (time_o),
    .time_valid_o (time_valid_o),
    .fault_q      (fault_q),
    .state        (state)
);

// File: tb/selfheal_clock_tb_top.sv
`timescale 1ns/100ps
module selfheal_clock_tb_top;

    localparam int NC = 8;
    localparam int DW = 4;

    typedef struct packed {
        logic [7:0]  mask;
        logic [15:0] ticks;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{8'h00, 16'd1},    '{8'h00, 16'd9},    '{8'h00, 16'd49},
        '{8'h00, 16'd1},    '{8'h01, 16'd7},    '{8'h01, 16'd600},
        '{8'h10, 16'd5},    '{8'h0F, 16'd3},    '{8'h1F, 16'd2},
        '{8'h00, 16'd3599}, '{8'h00, 16'd1},    '{8'h81, 16'd61}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_i = 1'b0;
    logic [NC-1:0]     fault_i = '0;
    logic [NC*DW-1:0]  digit_o;
    logic [4*DW-1:0]   time_o;
    logic              time_valid_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    selfheal_clock #(.NUM_CELLS(NC), .DIGIT_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .fault_i(fault_i),
        .digit_o(digit_o), .time_o(time_o), .time_valid_o(time_valid_o)
    );

    function automatic logic [15:0] bcd_of(int t);
        int mm = (t / 60) % 60;
        int ss = t % 60;
        return {4'(mm / 10), 4'(mm % 10), 4'(ss / 10), 4'(ss % 10)};
    endfunction

    function automatic int active_count(logic [NC-1:0] m);
        int n = 0;
        for (int i = 0; i < NC; i++) if (!m[i]) n++;
        return n;
    endfunction

    function automatic logic [NC*DW-1:0] exp_cells(logic [NC-1:0] m, int t);
        logic [NC*DW-1:0] v = '0;
        logic [15:0] b = bcd_of(t);
        int full = (active_count(m) / 4) * 4;
        int j = 0;
        for (int i = 0; i < NC; i++) begin
            if (!m[i]) begin
                if (j < full) v[i*DW +: DW] = b[(3 - (j % 4))*4 +: 4];
                j++;
            end
        end
        return v;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(string tag, logic [NC-1:0] m, int t);
        logic [15:0] et;
        logic        ev;
        ev = (active_count(m) >= 4);
        et = ev ? bcd_of(t) : 16'h0;
        check({tag, " R1 R2 R3 R5 R9 cells"}, 64'(digit_o), 64'(exp_cells(m, t)));
        check({tag, " R4 R7 time"}, 64'({time_valid_o, time_o}), 64'({ev, et}));
    endtask

    task automatic apply_mask(logic [NC-1:0] m);
        @(negedge clk); fault_i = m;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_ticks(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick_i = 1'b1;
        end
        @(negedge clk); tick_i = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [NC-1:0] cur;
        int t;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 reset", 64'({digit_o, time_o}), 64'(0));
        rst_n = 1'b1;
        cur = '0;
        t = 0;

        for (int k = 0; k < 12; k++) begin
            if (VECS[k].mask != cur) begin
                apply_mask(VECS[k].mask);
                cur = VECS[k].mask;
                t = 0;
            end
            do_ticks(int'(VECS[k].ticks));
            t = t + int'(VECS[k].ticks);
            check_all($sformatf("vec%0d", k), cur, t);
        end

        // R6: tick held through a fault change is ignored on the clear edge
        @(negedge clk); fault_i = 8'h02; tick_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R6 cleared", 64'(digit_o), 64'(exp_cells(8'h02, 0)));
        @(negedge clk); tick_i = 1'b0;
        check("R6 resume", 64'(digit_o), 64'(exp_cells(8'h02, 1)));

        // R4: wrap from 59:59 under a shifted group
        do_ticks(3598);
        check("R4 at 59:59", 64'(time_o), 64'(16'h5959));
        do_ticks(1);
        check("R4 wrap", 64'(time_o), 64'(16'h0000));

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule